// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects an on-chip host to an external asynchronous static RAM of 131,072 words of 24 bits each. The host offers one word at a time on a valid/ready port, with a write flag, a 17-bit address and 24 bits of write data. A read returns its data with a one-cycle strobe. On the memory side the block drives the address, three chip selects of mixed polarity, an output enable, a write enable and a split data bus: data out, data in, and one driver-enable bit for the pad buffer.

Each access runs for a whole number of clock cycles. The counts are worked out at elaboration from nanosecond timing limits and the clock period. Every write keeps the output enable high and opens with a turnaround cycle before the block drives the data bus. The write is ended by the write enable rising, and address and data are then held for one more cycle. Between accesses all three chip selects are held inactive, so the memory sits in standby and the shared bus is always released.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the access and its closing cycles have finished.
- R2: After reset and whenever idle, the chip selects are inactive ({cs0_n,cs1,cs2_n} = 3'b101), `mem_oe_n` = 1, `mem_we_n` = 1 and `mem_dq_oe` = 0.
- R3: A read selects the memory ({cs0_n,cs1,cs2_n} = 3'b010) with `mem_oe_n` = 0 and `mem_we_n` = 1 for RD_CYC = max(1, ceil(T_ACCESS_NS / CLK_PERIOD_NS)) cycles, starting on the edge that takes the request. During those cycles `mem_addr` holds the requested address.
- R4: `mem_dq_in` is captured into `rd_data` on the edge that ends the read-access cycles. `rd_valid` is high for exactly that one following cycle and at no other time.
- R5: A read is followed by RD_TURN = max(1, ceil(T_CS_HIZ_NS / CLK_PERIOD_NS)) cycles with the memory deselected and `mem_oe_n` high, before `req_ready` returns.
- R6: A write keeps `mem_oe_n` high throughout. It begins with WR_TURN = max(1, ceil(T_OE_HIZ_NS / CLK_PERIOD_NS)) cycles that select the memory with `mem_we_n` high and `mem_dq_oe` low.
- R7: `mem_we_n` is then low for WE_CYC = max(1, ceil(max(T_WE_PULSE_NS, T_DATA_SETUP_NS, T_ADDR_SETUP_NS) / CLK_PERIOD_NS)) cycles. During those cycles the memory is selected, `mem_dq_oe` = 1, `mem_dq_out` carries the write data and `mem_addr` carries the address.
- R8: After `mem_we_n` rises there is one hold cycle in which the memory stays selected and address and data are still driven unchanged. The next cycle releases the bus and deselects the memory.
- R9: `mem_dq_oe` is high only while `mem_oe_n` is high, so the controller never drives the bus while the memory may. The three chip selects are always all active or all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 24 | Captured read data |
| mem_addr | output | 17 | Memory address |
| mem_cs0_n | output | 1 | Chip select, active low |
| mem_cs1 | output | 1 | Chip select, active high |
| mem_cs2_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 24 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 24 | Data from the memory |

## Verification
The assertions assume that the host holds `req_write`, `req_addr` and `req_wdata` steady while `req_valid` waits for `req_ready`. They also assume that `mem_dq_in` carries the selected word by the end of the read-access cycles. The stimulus keeps within both assumptions. Its request driver changes fields only after a request has been taken. Its memory model puts a stored word on the data input only while the controller selects the memory with output enable low and write enable high, and it commits a write only when write enable rises with the memory still selected.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_e;

    // Pin-level control derived from the sequencer state
    typedef struct packed {
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    typedef struct packed {
        logic cs0_n;
        logic cs1;
        logic cs2_n;
    } cs_pins_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Round a nanosecond limit up to whole cycles, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic cs_pins_t cs_encode(input logic sel);
        cs_pins_t p;
        p.cs0_n = ~sel;
        p.cs1   = sel;
        p.cs2_n = ~sel;
        return p;
    endfunction

    function automatic pin_ctl_t ctl_for_state(input seq_state_e s);
        pin_ctl_t c;
        c = '{sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD_ACC:   c = '{sel: 1'b1, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            ST_WR_SETUP: c = '{sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            ST_WR_PULSE: c = '{sel: 1'b1, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_WR_HOLD:  c = '{sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            default:     c = '{sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!done) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned RD_CYC   = 3,
    parameter int unsigned RD_TURN  = 2,
    parameter int unsigned WR_TURN  = 1,
    parameter int unsigned WE_CYC   = 2,
    parameter int unsigned HOLD_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output seq_state_e       state_d,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             rd_capture
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] RDT_LD  = CNT_W'(RD_TURN - 1);
    localparam logic [CNT_W-1:0] WRT_LD  = CNT_W'(WR_TURN - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);

    seq_state_e state_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rd_capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = WRT_LD;
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = RD_LD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (timer_done) begin
                    rd_capture = 1'b1;
                    state_d    = ST_RD_TURN;
                    tmr_load   = 1'b1;
                    tmr_val    = RDT_LD;
                end
            end
            ST_RD_TURN: begin
                if (timer_done) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (timer_done) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WE_LD;
                end
            end
            ST_WR_PULSE: begin
                if (timer_done) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_WR_HOLD: begin
                if (timer_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_d,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output cs_pins_t          cs_pins,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    pin_ctl_t ctl_nx;

    assign ctl_nx = ctl_for_state(state_d);

    // Control pins come straight from flops so the memory sees no glitches
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pins   <= cs_encode(1'b0);
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            cs_pins   <= cs_encode(ctl_nx.sel);
            mem_oe_n  <= ctl_nx.oe_n;
            mem_we_n  <= ctl_nx.we_n;
            mem_dq_oe <= ctl_nx.drive;
        end
    end

    // Address and write data are latched once per access
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_capture;
            if (rd_capture) rd_data <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W          = 17,
    parameter int unsigned DATA_W          = 24,
    parameter int unsigned CLK_PERIOD_NS   = 4,
    parameter int unsigned T_ACCESS_NS     = 9,
    parameter int unsigned T_CS_HIZ_NS     = 5,
    parameter int unsigned T_OE_HIZ_NS     = 4,
    parameter int unsigned T_WE_PULSE_NS   = 7,
    parameter int unsigned T_DATA_SETUP_NS = 5,
    parameter int unsigned T_ADDR_SETUP_NS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs0_n,
    output logic              mem_cs1,
    output logic              mem_cs2_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC   = ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int unsigned RD_TURN  = ns_to_cycles(T_CS_HIZ_NS, CLK_PERIOD_NS);
    localparam int unsigned WR_TURN  = ns_to_cycles(T_OE_HIZ_NS, CLK_PERIOD_NS);
    localparam int unsigned WE_NS    = max_u(T_WE_PULSE_NS, max_u(T_DATA_SETUP_NS, T_ADDR_SETUP_NS));
    localparam int unsigned WE_CYC   = ns_to_cycles(WE_NS, CLK_PERIOD_NS);
    localparam int unsigned HOLD_CYC = 1;
    localparam int unsigned MAX_CYC  = max_u(max_u(RD_CYC, RD_TURN), max_u(WR_TURN, WE_CYC));
    localparam int unsigned CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    seq_state_e       state_d;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             rd_capture;
    cs_pins_t         cs_pins;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .RD_TURN  (RD_TURN),
        .WR_TURN  (WR_TURN),
        .WE_CYC   (WE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timer_done (tmr_done),
        .state_d    (state_d),
        .req_ready  (req_ready),
        .accept     (accept),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .rd_capture (rd_capture)
    );

    sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .state_d    (state_d),
        .accept     (accept),
        .rd_capture (rd_capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .cs_pins    (cs_pins),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign mem_cs0_n = cs_pins.cs0_n;
    assign mem_cs1   = cs_pins.cs1;
    assign mem_cs2_n = cs_pins.cs2_n;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs0_n,
    input logic              mem_cs1,
    input logic              mem_cs2_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic sel;
    assign sel = ({mem_cs0_n, mem_cs1, mem_cs2_n} == 3'b010);

    AST_CS_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst) sel || ({mem_cs0_n, mem_cs1, mem_cs2_n} == 3'b101)) else $error("cs mix"); // R9
    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> mem_oe_n) else $error("bus clash"); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) req_ready |-> (!sel && mem_oe_n && mem_we_n && !mem_dq_oe)) else $error("idle pins"); // R2
    AST_WE_LOW_DRIVEN: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (sel && mem_dq_oe && mem_oe_n)) else $error("we low"); // R7
    AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_we_n && $past(!mem_we_n)) |-> (sel && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out))) else $error("hold"); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) (sel && $past(sel)) |-> $stable(mem_addr)) else $error("addr moved"); // R3
    AST_RDVALID_SINGLE: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid) else $error("rv width"); // R4
    AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst) rd_valid |-> ($past(!mem_oe_n) && mem_oe_n)) else $error("rv origin"); // R4
endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int CLK_PERIOD = 4;
    localparam int AW = 17;
    localparam int DW = 24;
    localparam int T_ACC = 9, T_CSZ = 5, T_OEZ = 4, T_WEP = 7, T_DSU = 5, T_ASU = 7;

    function automatic int cdiv(input int t);
        int c;
        c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int N_RD   = (T_ACC + CLK_PERIOD - 1) / CLK_PERIOD;
    int n_rdt, n_wrt, n_we;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data, mem_dq_out;
    logic [DW-1:0] mem_dq_in = 24'h5A5A5A;
    logic [AW-1:0] mem_addr;
    logic mem_cs0_n, mem_cs1, mem_cs2_n, mem_oe_n, mem_we_n, mem_dq_oe;

    sram_async_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs0_n(mem_cs0_n), .mem_cs1(mem_cs1), .mem_cs2_n(mem_cs2_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        bit            rdy;
        bit            sel;
        bit            oe_n;
        bit            we_n;
        bit            drv;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        bit            rv;
        logic [DW-1:0] rdat;
        string         tag;
    } exp_t;

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            gap;
    } op_t;

    exp_t sched[$];
    op_t  ops[$];
    logic [DW-1:0] refmem [int];
    logic [DW-1:0] pinmem [int];
    int checks = 0, errors = 0, cycles = 0, gap_cnt = 0, tail = 0;
    bit taken = 0, prev_we_n = 1, done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, expv, cycles);
        end
    endtask

    function automatic exp_t idle_exp();
        exp_t e;
        e.rdy = 1; e.sel = 0; e.oe_n = 1; e.we_n = 1; e.drv = 0;
        e.addr = '0; e.dout = '0; e.rv = 0; e.rdat = '0; e.tag = "R2";
        return e;
    endfunction

    function automatic exp_t busy_exp(input bit sel, input bit oe_n, input bit we_n,
                                      input bit drv, input logic [AW-1:0] a,
                                      input logic [DW-1:0] d, input string tag);
        exp_t e;
        e = idle_exp();
        e.rdy = 0; e.sel = sel; e.oe_n = oe_n; e.we_n = we_n; e.drv = drv;
        e.addr = a; e.dout = d; e.tag = tag;
        return e;
    endfunction

    // Build the per-cycle schedule of an access taken at the coming edge
    task automatic push_access(input op_t o);
        exp_t e;
        if (!o.wr) begin
            for (int i = 0; i < N_RD; i++) sched.push_back(busy_exp(1, 0, 1, 0, o.addr, '0, "R3"));
            for (int i = 0; i < n_rdt; i++) begin
                e = busy_exp(0, 1, 1, 0, o.addr, '0, "R5");
                if (i == 0) begin
                    e.rv = 1;
                    e.rdat = refmem.exists(int'(o.addr)) ? refmem[int'(o.addr)] : '0;
                end
                sched.push_back(e);
            end
        end else begin
            for (int i = 0; i < n_wrt; i++) sched.push_back(busy_exp(1, 1, 1, 0, o.addr, o.data, "R6"));
            for (int i = 0; i < n_we; i++) sched.push_back(busy_exp(1, 1, 0, 1, o.addr, o.data, "R7"));
            sched.push_back(busy_exp(1, 1, 1, 1, o.addr, o.data, "R8"));
            refmem[int'(o.addr)] = o.data;
        end
    endtask

    task automatic compare(input exp_t e);
        logic [2:0] cs;
        cs = {mem_cs0_n, mem_cs1, mem_cs2_n};
        chk(req_ready == e.rdy, "R1", "req_ready", 32'(req_ready), 32'(e.rdy));
        chk(cs == (e.sel ? 3'b010 : 3'b101), e.tag, "chip selects", 32'(cs), e.sel ? 32'h2 : 32'h5);
        chk(mem_oe_n == e.oe_n, e.tag, "mem_oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk(mem_we_n == e.we_n, e.tag, "mem_we_n", 32'(mem_we_n), 32'(e.we_n));
        chk(mem_dq_oe == e.drv, e.tag, "mem_dq_oe", 32'(mem_dq_oe), 32'(e.drv));
        if (e.sel) chk(mem_addr == e.addr, e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
        if (e.drv) chk(mem_dq_out == e.dout, e.tag, "mem_dq_out", 32'(mem_dq_out), 32'(e.dout));
        chk(rd_valid == e.rv, "R4", "rd_valid", 32'(rd_valid), 32'(e.rv));
        if (e.rv) chk(rd_data == e.rdat, "R4", "rd_data", 32'(rd_data), 32'(e.rdat));
        // R9: the memory drives whenever selected with OE low and WE high
        chk(!((cs == 3'b010) && !mem_oe_n && mem_we_n && mem_dq_oe), "R9", "bus clash",
            32'(mem_dq_oe), 32'h0);
    endtask

    task automatic add_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        op_t o;
        o.wr = wr; o.addr = a; o.data = d; o.gap = gap;
        ops.push_back(o);
    endtask

    initial begin
        n_rdt = cdiv(T_CSZ);
        n_wrt = cdiv(T_OEZ);
        n_we  = cdiv((T_WEP > T_DSU) ? ((T_WEP > T_ASU) ? T_WEP : T_ASU) : ((T_DSU > T_ASU) ? T_DSU : T_ASU));
        add_op(1, 17'h00000, 24'h123456, 0);
        add_op(0, 17'h00000, 24'h0, 0);
        add_op(1, 17'h1FFFF, 24'hFFFFFF, 2);   // top address, all ones
        add_op(0, 17'h1FFFF, 24'h0, 1);
        add_op(1, 17'h0AAAA, 24'hA5A5A5, 0);
        add_op(1, 17'h0AAAA, 24'h5A5A5A, 0);   // overwrite back to back
        add_op(0, 17'h0AAAA, 24'h0, 0);
        add_op(0, 17'h00555, 24'h0, 3);        // never written: reads zero
        add_op(1, 17'h00001, 24'h000000, 0);
        add_op(0, 17'h00001, 24'h0, 0);
        add_op(0, 17'h00000, 24'h0, 0);
        for (int i = 0; i < 40; i++)
            add_op(i[0], AW'((i * 4099 + 7) % 131072) & 17'h1FFF0,
                   DW'(i * 24'h010101) ^ 24'h3C3C3C, i % 3);
    end

    always @(negedge clk) begin
        exp_t e;
        logic sel_now;
        cycles++;
        if (cycles == 5) rst = 1'b0;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected<=%0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst) begin
            if (cycles > 1) compare(idle_exp());   // R2 reset state
        end else begin
            e = (sched.size() > 0) ? sched.pop_front() : idle_exp();
            compare(e);
        end

        // Memory pin model
        sel_now = ({mem_cs0_n, mem_cs1, mem_cs2_n} == 3'b010);
        if (!rst && !prev_we_n && mem_we_n && sel_now) pinmem[int'(mem_addr)] = mem_dq_out;
        prev_we_n = mem_we_n;
        if (sel_now && !mem_oe_n && mem_we_n)
            mem_dq_in = pinmem.exists(int'(mem_addr)) ? pinmem[int'(mem_addr)] : '0;
        else
            mem_dq_in = 24'h5A5A5A;

        // Request driver
        if (!rst) begin
            if (taken) req_valid = 1'b0;
            if (!req_valid && ops.size() > 0) begin
                if (gap_cnt < ops[0].gap) gap_cnt++;
                else begin
                    req_valid = 1'b1;
                    req_write = ops[0].wr;
                    req_addr  = ops[0].addr;
                    req_wdata = ops[0].data;
                    gap_cnt = 0;
                end
            end
            taken = req_valid && req_ready;
            if (taken) begin
                op_t o;
                o = ops.pop_front();
                push_access(o);
            end
            if (ops.size() == 0 && sched.size() == 0 && !req_valid && !done) begin
                tail++;
                if (tail == 4) begin
                    done = 1;
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        end
    end
endmodule